// File: doc/BRIEF.md
# Trace Message Queue with Overflow Recovery

This block is a queue for debug trace messages. It sits between the trace producers of a processor core and the unit that formats messages for the debug port. Each cycle a producer may offer one message. The message carries a class tag that names its source: program trace, ownership trace or watchpoint. Accepted messages leave in order through a read port with a valid/ready handshake.

When a message arrives while the queue is full, the block enters a drain mode. In drain mode it refuses every offered message, and the reader keeps emptying the queue. For each class that lost a message, including the message that caused the overflow, the block sets a flag. In the first cycle of drain mode in which the queue is empty, it writes one error message. The code of that error message summarises the flags. The flags then clear and normal acceptance resumes.

An optional stall output asks the core to hold back when the queue is nearly full. This lowers the chance of an overrun but cannot rule one out.

Top module: `trace_ovf_queue`

## Requirements
- R1: After reset the queue is empty, `rd_valid_o` is 0 and `stall_o` is 0.
- R2: Outside drain mode, a message offered while the occupancy is below DEPTH is stored. Stored messages are presented at the read port in arrival order with `rd_err_o`=0. A transfer happens when `rd_valid_o` and `rd_ready_i` are both 1.
- R3: A message offered while the occupancy equals DEPTH is discarded, and the block enters drain mode.
- R4: In drain mode, every offered message is discarded while the occupancy is nonzero. Reads continue as normal.
- R5: In the first cycle of drain mode in which the occupancy is zero, one error message is written. It then appears at the read port with `rd_err_o`=1, `rd_data_o[4:0]` equal to the error code and all upper data bits 0. The block then leaves drain mode.
- R6: Class encoding on `wr_class_i`: 0 is program trace, 1 is ownership trace, 2 and 3 are watchpoint. The error code is chosen as follows:
  - 5'b01000 if any watchpoint message was dropped;
  - otherwise 5'b00111 if both program and ownership trace messages were dropped;
  - 5'b00001 if only program trace messages were dropped;
  - 5'b00010 if only ownership trace messages were dropped.
- R7: The class flags include the message that caused the overflow. They are cleared when the error message is written, so a later overflow reports only its own classes.
- R8: A message offered in the same cycle that the error message is written is discarded. Its class is included in that error message's code.
- R9: `stall_o` is 1 exactly when `stall_en_i` is 1 and the occupancy is at least DEPTH-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | A message is offered this cycle |
| wr_class_i | input | 2 | Class tag of the offered message |
| wr_data_i | input | MSG_W | Offered message payload |
| rd_ready_i | input | 1 | Formatter takes the head message |
| rd_valid_o | output | 1 | Head message is present |
| rd_err_o | output | 1 | Head message is an overflow error message |
| rd_data_o | output | MSG_W | Head payload, or the error code in bits 4:0 |
| stall_en_i | input | 1 | Enables the core stall request |
| stall_o | output | 1 | Stall request toward the core |

## Verification
Two functions can fall in the same cycle. In the cycle where the drained queue is empty, the error message is written, and a new message may be offered at that same moment. The bench provokes this by offering a watchpoint message exactly when its model shows an empty queue in drain mode, after an overflow caused by a program trace message. It judges the outcome by two things: the error code read out must be 5'b01000, and that message must never appear at the read port.

// File: rtl/trace_ovf_pkg.sv
package trace_ovf_pkg;
  localparam int unsigned CODE_W = 5;

  typedef enum logic [1:0] {
    CLS_PROG  = 2'd0,
    CLS_OWN   = 2'd1,
    CLS_WATCH = 2'd2,
    CLS_WATCH_ALT = 2'd3
  } msg_class_e;

  // flag vector: [0] program, [1] ownership, [2] watchpoint
  typedef logic [2:0] class_flags_t;

  localparam logic [CODE_W-1:0] CODE_PROG  = 5'b00001;
  localparam logic [CODE_W-1:0] CODE_OWN   = 5'b00010;
  localparam logic [CODE_W-1:0] CODE_BOTH  = 5'b00111;
  localparam logic [CODE_W-1:0] CODE_WATCH = 5'b01000;

  function automatic class_flags_t class_to_flag(input logic [1:0] cls);
    unique case (cls)
      2'd0:    return 3'b001;
      2'd1:    return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] flags_to_code(input class_flags_t f);
    if (f[2])             return CODE_WATCH;
    else if (f[0] && f[1]) return CODE_BOTH;
    else if (f[1])        return CODE_OWN;
    else                  return CODE_PROG;
  endfunction
endpackage

// File: rtl/tovq_fifo.sv
module tovq_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned ENT_W = 33,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [ENT_W-1:0] push_ent_i,
  input  logic             pop_i,
  output logic [ENT_W-1:0] head_ent_o,
  output logic [CW-1:0]    count_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [ENT_W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) wptr_q <= ptr_inc(wptr_q);
      if (pop_i)  rptr_q <= ptr_inc(rptr_q);
      if (push_i && !pop_i)      count_q <= count_q + 1'b1;
      else if (pop_i && !push_i) count_q <= count_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= push_ent_i;
  end

  assign head_ent_o = mem_q[rptr_q];
  assign count_o    = count_q;
  assign empty_o    = (count_q == '0);
  assign full_o     = (count_q == CW'(DEPTH));

  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);
  // R2
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i);
  // R1
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
endmodule

// File: rtl/tovq_ovf_ctrl.sv
module tovq_ovf_ctrl
  import trace_ovf_pkg::*;
#(
  parameter int unsigned MSG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [1:0]       wr_class_i,
  input  logic [MSG_W-1:0] wr_data_i,
  input  logic             empty_i,
  input  logic             full_i,
  output logic             push_o,
  output logic [MSG_W:0]   push_ent_o
);
  logic         drain_q;
  class_flags_t flags_q, flags_d, flags_now;
  logic         drain_d, err_push, data_push;
  logic [CODE_W-1:0] err_code;

  assign flags_now = flags_q | (wr_valid_i ? class_to_flag(wr_class_i) : 3'b000);
  assign err_code  = flags_to_code(flags_now);

  always_comb begin
    drain_d   = drain_q;
    flags_d   = flags_q;
    err_push  = 1'b0;
    data_push = 1'b0;
    if (drain_q) begin
      if (empty_i) begin
        err_push = 1'b1;
        drain_d  = 1'b0;
        flags_d  = '0;
      end else begin
        flags_d  = flags_now;
      end
    end else if (wr_valid_i) begin
      if (full_i) begin
        drain_d = 1'b1;
        flags_d = flags_now;
      end else begin
        data_push = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drain_q <= 1'b0;
      flags_q <= '0;
    end else begin
      drain_q <= drain_d;
      flags_q <= flags_d;
    end
  end

  assign push_o     = err_push | data_push;
  assign push_ent_o = err_push ? {1'b1, {(MSG_W-CODE_W){1'b0}}, err_code}
                               : {1'b0, wr_data_i};

  // R3
  ovf_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drain_q && wr_valid_i && full_i) |=> drain_q);
  // R4
  drain_no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_q && !empty_i) |-> !push_o);
  // R5
  err_when_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && push_ent_o[MSG_W]) |-> empty_i);
  // R5
  err_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && push_ent_o[MSG_W]) |=> (!drain_q && flags_q == '0));
  // R7
  flags_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drain_q |-> (flags_q == '0));
endmodule

// File: rtl/trace_ovf_queue.sv
module trace_ovf_queue #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned MSG_W = 32,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [1:0]       wr_class_i,
  input  logic [MSG_W-1:0] wr_data_i,
  input  logic             rd_ready_i,
  output logic             rd_valid_o,
  output logic             rd_err_o,
  output logic [MSG_W-1:0] rd_data_o,
  input  logic             stall_en_i,
  output logic             stall_o
);
  logic           push, pop, empty, full;
  logic [MSG_W:0] push_ent, head_ent;
  logic [CW-1:0]  count;

  tovq_ovf_ctrl #(.MSG_W(MSG_W)) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_class_i (wr_class_i),
    .wr_data_i  (wr_data_i),
    .empty_i    (empty),
    .full_i     (full),
    .push_o     (push),
    .push_ent_o (push_ent)
  );

  tovq_fifo #(.DEPTH(DEPTH), .ENT_W(MSG_W + 1)) fifo_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_ent_i (push_ent),
    .pop_i      (pop),
    .head_ent_o (head_ent),
    .count_o    (count),
    .empty_o    (empty),
    .full_o     (full)
  );

  assign rd_valid_o = !empty;
  assign pop        = rd_valid_o && rd_ready_i;
  assign rd_err_o   = rd_valid_o && head_ent[MSG_W];
  assign rd_data_o  = rd_valid_o ? head_ent[MSG_W-1:0] : '0;
  assign stall_o    = stall_en_i && (count >= CW'(DEPTH - 2));

  // R9
  stall_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_en_i |-> !stall_o);
  // R5
  err_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> (rd_data_o[MSG_W-1:5] == '0));
endmodule

// File: tb/trace_ovf_queue_tb.sv
`timescale 1ns/1ps
module trace_ovf_queue_tb_top;
  localparam int DEPTH = 16;
  localparam int MSG_W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_ready = 1'b0, stall_en = 1'b0;
  logic [1:0] wr_class = '0;
  logic [MSG_W-1:0] wr_data = '0;
  logic rd_valid, rd_err, stall;
  logic [MSG_W-1:0] rd_data;

  int checks = 0, failures = 0;
  int cycles = 0;

  // reference model
  logic [MSG_W:0] m_q[$];
  bit m_drain = 0;
  bit [2:0] m_flags = 0;
  int data_reads = 0;
  logic [4:0] last_code = '0;
  int err_reads = 0;
  int seq = 1;

  always #2.5 clk = ~clk;

  trace_ovf_queue #(.DEPTH(DEPTH), .MSG_W(MSG_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_class_i(wr_class),
    .wr_data_i(wr_data), .rd_ready_i(rd_ready), .rd_valid_o(rd_valid),
    .rd_err_o(rd_err), .rd_data_o(rd_data), .stall_en_i(stall_en), .stall_o(stall)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic bit [2:0] cls_flag(input logic [1:0] c);
    return (c == 2'd0) ? 3'b001 : (c == 2'd1) ? 3'b010 : 3'b100;
  endfunction

  function automatic logic [4:0] code_of(input bit [2:0] f);
    if (f[2]) return 5'b01000;
    if (f[0] && f[1]) return 5'b00111;
    if (f[1]) return 5'b00010;
    return 5'b00001;
  endfunction

  // compare at negedge, apply inputs, advance model across the posedge
  task automatic step(input bit wv, input logic [1:0] cls, input bit rdy, input bit sen);
    bit exp_v;
    logic [MSG_W:0] head;
    bit pop;
    @(negedge clk);
    exp_v = (m_q.size() != 0);
    head  = exp_v ? m_q[0] : '0;
    chk("R2 rd_valid", rd_valid, exp_v);
    chk(head[MSG_W] ? "R5 rd_err" : "R2 rd_err", rd_err, head[MSG_W]);
    chk(head[MSG_W] ? "R5 err data" : "R2 data", rd_data, head[MSG_W-1:0]);
    wr_valid = wv; wr_class = cls; wr_data = seq; rd_ready = rdy; stall_en = sen;
    #0.5;
    chk("R9 stall", stall, sen && (m_q.size() >= DEPTH - 2));
    pop = exp_v && rdy;
    if (pop) begin
      if (head[MSG_W]) begin last_code = head[4:0]; err_reads++; end
      else data_reads++;
      void'(m_q.pop_front());
    end
    if (m_drain) begin
      if (m_q.size() == 0 && !pop) begin
        m_flags |= wv ? cls_flag(cls) : 3'b000;
        m_q.push_back({1'b1, 27'd0, code_of(m_flags)});
        m_flags = 0; m_drain = 0;
      end else if (wv) m_flags |= cls_flag(cls);
    end else if (wv) begin
      if (m_q.size() + (pop ? 1 : 0) == DEPTH) begin
        m_drain = 1; m_flags |= cls_flag(cls);
      end else m_q.push_back({1'b0, MSG_W'(seq)});
    end
    seq++;
    @(posedge clk);
    cycles++;
  endtask

  // fill, overflow with trigger, drain while offering extra class; expect code
  task automatic run_ovf(input string req, input logic [1:0] trig, input bit extra_en,
                         input logic [1:0] extra, input bit at_empty_en,
                         input logic [1:0] at_empty, input logic [4:0] exp_code);
    int er0;
    int guard;
    data_reads = 0;
    er0 = err_reads;
    for (int i = 0; i < DEPTH; i++) step(1, 2'd0, 0, 0);
    step(1, trig, 0, 0);
    guard = 0;
    while (err_reads == er0 && guard < 200) begin
      bit wv;
      logic [1:0] c;
      wv = 0; c = 2'd0;
      if (extra_en && m_drain && m_q.size() > DEPTH / 2) begin wv = 1; c = extra; end
      if (at_empty_en && m_drain && m_q.size() == 0) begin wv = 1; c = at_empty; end
      step(wv, c, 1, 0);
      guard++;
    end
    chk({req, " code"}, last_code, exp_code);
    chk("R3 R4 data reads", data_reads, DEPTH);
    // normal acceptance resumes
    step(1, 2'd1, 0, 0);
    step(0, 2'd0, 1, 0);
    step(0, 2'd0, 0, 0);
    chk("R5 resume", data_reads, DEPTH + 1);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1;
    // R1
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 stall", stall, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
    step(0, 2'd0, 0, 1);
    chk("R1 empty after reset", data_reads + err_reads, 0);
    // R2 ordering with stall enabled (R9 threshold crossing)
    for (int i = 0; i < DEPTH; i++) step(1, 2'(i % 3), 0, 1);
    for (int i = 0; i < DEPTH; i++) step(0, 2'd0, 1, 1);
    step(0, 2'd0, 0, 1);
    // R6 R7 scenarios
    run_ovf("R6 R7 prog only", 2'd0, 0, 2'd0, 0, 2'd0, 5'b00001);
    run_ovf("R6 own only", 2'd1, 0, 2'd0, 0, 2'd0, 5'b00010);
    run_ovf("R6 own+prog", 2'd1, 1, 2'd0, 0, 2'd0, 5'b00111);
    run_ovf("R6 prog+own", 2'd0, 1, 2'd1, 0, 2'd0, 5'b00111);
    run_ovf("R6 watch alt", 2'd3, 1, 2'd0, 0, 2'd0, 5'b01000);
    run_ovf("R7 flags cleared", 2'd0, 0, 2'd0, 0, 2'd0, 5'b00001);
    run_ovf("R8 same cycle", 2'd0, 0, 2'd0, 1, 2'd2, 5'b01000);
    run_ovf("R8 R6 own at empty", 2'd0, 0, 2'd0, 1, 2'd1, 5'b00111);
    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom;
      step(r[1:0] != 0, r[3:2], (i % 500) < 250 ? r[5:4] == 0 : r[5:4] != 0, r[6]);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule